// File: doc/BRIEF.md
# Programmable Three-Way Peripheral Bus Arbiter

This block decides which of three masters owns a shared peripheral bus: a host processor, a DMA engine and an OCP initiator. Each master raises a request line. Once it is granted, it keeps the bus until it pulses its access-done strobe. The next owner is then picked on that same clock edge. An idle bus is also re-arbitrated on every edge.

A single 5-bit policy register, written through a simple write-enable port, sets three things:
- how the DMA and OCP masters are ordered against each other;
- whether the processor is always preferred, or instead waits while the DMA/OCP side completes a programmable burst of 1 to 7 accesses;
- whether an interrupt or fast-interrupt state on the processor puts it on equal footing with the other two, served in a three-way rotation.

The burst allowance is held in a down-counter. The counter is refilled whenever the processor wins the bus and whenever the policy register is written.

Top module: `periph_bus_arbiter`

## Requirements
- R1: After reset no grant is asserted and the policy register holds round-robin ordering, exception sharing enabled and a burst of 1. With the processor and the DMA both requesting, the DMA is granted first, and the processor is granted after one DMA done strobe.
- R2: At most one bit of `grant_o` is set at any time, and `grant_o` is 0 whenever the bus is free and no request is raised. Requester bit positions are 0 = processor, 1 = DMA, 2 = OCP in `req_i`, `done_i` and `grant_o`.
- R3: A grant stays unchanged until the granted master pulses its own `done_i` bit. The next owner appears in `grant_o` after that clock edge. A free bus with pending requests is granted on the next edge.
- R4: A write with `cfg_we_i` high loads `cfg_wdata_i` on the clock edge. Bit 4 selects fixed ordering (1) or round-robin (0) between DMA and OCP. Bit 3 enables exception sharing. Bits 2:0 hold the burst field. The new value governs arbitration from the next edge, and the write also refills the burst counter.
- R5: With the burst field at 000 and exception sharing inactive, a requesting processor wins every arbitration.
- R6: With a burst field N of 1 to 7, each processor grant refills the counter to N. Every DMA/OCP done strobe decrements it, saturating at 0. While the counter is non-zero and the DMA/OCP side requests, the processor waits. When the counter reaches 0, a waiting processor is granted at the next arbitration.
- R7: If neither DMA nor OCP requests at an arbitration, a requesting processor is granted even when burst count remains.
- R8: In round-robin ordering, DMA and OCP alternate when both request. After reset the DMA goes first.
- R9: In fixed ordering, the DMA wins over the OCP whenever both request.
- R10: With sharing enabled and `cpu_irq_i` or `cpu_fiq_i` high, all three masters rotate in the order processor, DMA, OCP, ignoring the burst counter. After reset the processor is first in this rotation.
- R11: With sharing disabled, `cpu_irq_i` and `cpu_fiq_i` have no effect on arbitration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 3 | Bus requests (0 processor, 1 DMA, 2 OCP) |
| done_i | input | 3 | Access-done strobes, one per master |
| cpu_irq_i | input | 1 | Processor is in interrupt mode |
| cpu_fiq_i | input | 1 | Processor is in fast-interrupt mode |
| cfg_we_i | input | 1 | Policy register write enable |
| cfg_wdata_i | input | 5 | Policy register write data |
| grant_o | output | 3 | One-hot bus grant |

## Verification
Most internal faults here are hidden until a later arbitration. A corrupted burst counter shows up only when the processor is finally granted: one done strobe too early or too late. A stale rotation pointer shows up as the wrong master at the next contested decision. Both therefore surface within a few done strobes after the faulty state arises. The directed scenarios count done strobes exactly, and they check the grant after every one so that an off-by-one handover is caught. A wrongly decoded policy bit changes which master wins the very first contested edge after the write, so each policy is probed immediately after it is programmed.

// File: rtl/pba_pkg.sv
package pba_pkg;
  localparam int NREQ   = 3;
  localparam int BW     = 3;
  localparam int CFG_W  = BW + 2;
  localparam int IDX_W  = 2;
  localparam int CPU    = 0;
  localparam int DMA    = 1;
  localparam int OCP    = 2;
  localparam logic [BW-1:0] BURST_RST = 3'd1;

  typedef struct packed {
    logic          fixed_order;
    logic          share_en;
    logic [BW-1:0] burst;
  } policy_t;

  // Rotating pick among three masters, starting after 'last'.
  function automatic logic [NREQ-1:0] rot3_pick(input logic [NREQ-1:0] rq,
                                                 input logic [IDX_W-1:0] last);
    logic [NREQ-1:0] g;
    int              idx;
    g = '0;
    for (int k = 1; k <= NREQ; k++) begin
      idx = (int'(last) + k) % NREQ;
      if (g == '0 && rq[idx]) g[idx] = 1'b1;
    end
    return g;
  endfunction

  // Pick between DMA and OCP; result bits: [0] DMA, [1] OCP.
  function automatic logic [1:0] pair_pick(input logic rq_dma, input logic rq_ocp,
                                           input logic fixed, input logic last_was_ocp);
    logic [1:0] g;
    g = 2'b00;
    if (rq_dma && rq_ocp) begin
      if (fixed || last_was_ocp) g = 2'b01;
      else                       g = 2'b10;
    end else if (rq_dma) g = 2'b01;
    else if (rq_ocp)     g = 2'b10;
    return g;
  endfunction

  // Index of a one-hot vector (0 when empty).
  function automatic logic [IDX_W-1:0] onehot_idx(input logic [NREQ-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int k = 0; k < NREQ; k++)
      if (v[k]) r = IDX_W'(k);
    return r;
  endfunction

  // Counter value after an optional saturating decrement.
  function automatic logic [BW-1:0] sat_dec(input logic [BW-1:0] c, input logic dec);
    return (dec && c != '0) ? c - 1'b1 : c;
  endfunction
endpackage

// File: rtl/pba_policy_reg.sv
module pba_policy_reg
  import pba_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output policy_t          pol
);
  policy_t pol_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_q.fixed_order <= 1'b0;
      pol_q.share_en    <= 1'b1;
      pol_q.burst       <= BURST_RST;
    end else if (we) begin
      pol_q <= policy_t'(wdata);
    end
  end

  assign pol = pol_q;

  p_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> pol == $past(wdata));
endmodule

// File: rtl/pba_burst_ctr.sv
module pba_burst_ctr
  import pba_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload,
  input  logic [BW-1:0] load_val,
  input  logic          dec,
  output logic [BW-1:0] cnt_eff
);
  logic [BW-1:0] cnt_q;

  assign cnt_eff = sat_dec(cnt_q, dec);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= BURST_RST;
    else if (reload) cnt_q <= load_val;
    else             cnt_q <= cnt_eff;
  end

  p_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !reload) |=> cnt_q == '0);
  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> cnt_q == $past(load_val));
endmodule

// File: rtl/pba_grant_select.sv
module pba_grant_select
  import pba_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req,
  input  policy_t         pol,
  input  logic            shared_mode,
  input  logic [BW-1:0]   cnt_eff,
  input  logic            issue,
  output logic [NREQ-1:0] next_grant
);
  logic [IDX_W-1:0] last3_q;
  logic             last_ocp_q;
  logic [1:0]       pair;
  logic             pair_any;

  assign pair     = pair_pick(req[DMA], req[OCP], pol.fixed_order, last_ocp_q);
  assign pair_any = req[DMA] | req[OCP];

  always_comb begin
    if (shared_mode)
      next_grant = rot3_pick(req, last3_q);
    else if (pol.burst == '0)
      next_grant = req[CPU] ? 3'b001 : {pair, 1'b0};
    else if (pair_any && cnt_eff != '0)
      next_grant = {pair, 1'b0};
    else if (req[CPU])
      next_grant = 3'b001;
    else
      next_grant = {pair, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last3_q    <= IDX_W'(OCP);
      last_ocp_q <= 1'b1;
    end else if (issue && next_grant != '0) begin
      last3_q <= onehot_idx(next_grant);
      if (next_grant[DMA]) last_ocp_q <= 1'b0;
      if (next_grant[OCP]) last_ocp_q <= 1'b1;
    end
  end

  p_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !shared_mode && pol.fixed_order && req[DMA]) |-> !next_grant[OCP]);
endmodule

// File: rtl/periph_bus_arbiter.sv
module periph_bus_arbiter
  import pba_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NREQ-1:0]  req_i,
  input  logic [NREQ-1:0]  done_i,
  input  logic             cpu_irq_i,
  input  logic             cpu_fiq_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [NREQ-1:0]  grant_o
);
  policy_t         pol;
  logic            shared_mode;
  logic            owner_done;
  logic            issue;
  logic            pair_done;
  logic            cpu_win;
  logic            ctr_reload;
  logic [BW-1:0]   ctr_load;
  logic [BW-1:0]   cnt_eff;
  logic [NREQ-1:0] next_grant;
  logic [NREQ-1:0] grant_q;

  pba_policy_reg u_pol (
    .clk(clk), .rst_n(rst_n), .we(cfg_we_i), .wdata(cfg_wdata_i), .pol(pol)
  );

  assign shared_mode = pol.share_en & (cpu_irq_i | cpu_fiq_i);
  assign owner_done  = |(done_i & grant_q);
  assign issue       = (grant_q == '0) | owner_done;
  assign pair_done   = owner_done & (grant_q[DMA] | grant_q[OCP]);
  assign cpu_win     = issue & next_grant[CPU];
  assign ctr_reload  = cfg_we_i | cpu_win;
  assign ctr_load    = cfg_we_i ? cfg_wdata_i[BW-1:0] : pol.burst;

  pba_burst_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .reload(ctr_reload), .load_val(ctr_load),
    .dec(pair_done), .cnt_eff(cnt_eff)
  );

  pba_grant_select u_sel (
    .clk(clk), .rst_n(rst_n), .req(req_i), .pol(pol), .shared_mode(shared_mode),
    .cnt_eff(cnt_eff), .issue(issue), .next_grant(next_grant)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     grant_q <= '0;
    else if (issue) grant_q <= next_grant;
  end

  assign grant_o = grant_q;

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && req_i == '0) |=> grant_o == '0);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0 && !owner_done) |=> $stable(grant_o));
  p_cpu_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !shared_mode && pol.burst == '0 && req_i[CPU]) |=> grant_o == 3'b001);
  p_early_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !shared_mode && req_i == 3'b001) |=> grant_o == 3'b001);
endmodule

// File: tb/tb_periph_bus_arbiter.sv
`timescale 1ns/100ps
module tb_periph_bus_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] req = '0, done = '0;
  logic       irq = 1'b0, fiq = 1'b0, we = 1'b0;
  logic [4:0] wdata = '0;
  logic [2:0] grant;
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  localparam logic [2:0] G_NONE = 3'b000, G_CPU = 3'b001, G_DMA = 3'b010, G_OCP = 3'b100;

  always #2.5 clk = ~clk;

  periph_bus_arbiter dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .done_i(done), .cpu_irq_i(irq),
    .cpu_fiq_i(fiq), .cfg_we_i(we), .cfg_wdata_i(wdata), .grant_o(grant)
  );

  // policy word: [4] fixed order, [3] sharing enable, [2:0] burst
  function automatic logic [4:0] pol(input logic fixed, input logic share, input logic [2:0] b);
    return {fixed, share, b};
  endfunction

  task automatic check(input string rq, input logic [2:0] exp);
    n_cmp++;
    if (grant !== exp) begin
      n_bad++;
      $display("FAIL %s: grant=%b expected=%b at %0t", rq, grant, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    req = '0; done = '0; irq = 0; fiq = 0; we = 0;
    rst_n = 0; tick(); tick(); rst_n = 1; tick();
  endtask

  task automatic write_pol(input logic [4:0] v);
    we = 1; wdata = v; tick(); we = 0; tick();
  endtask

  task automatic finish_access(input logic [2:0] who);
    done = who; tick(); done = '0;
  endtask

  task automatic t_reset_defaults();
    do_reset();
    check("R1 reset grant", G_NONE);
    tick(); check("R2 idle no grant", G_NONE);
    req = G_CPU | G_DMA; tick();
    check("R1 default burst DMA first", G_DMA);
    tick(); tick();
    check("R3 grant held without done", G_DMA);
    finish_access(G_DMA);
    check("R1 CPU after one DMA access", G_CPU);
    finish_access(G_CPU);
    check("R6 reload to 1 gives DMA", G_DMA);
    req = '0; finish_access(G_DMA);
    check("R2 free after done no req", G_NONE);
  endtask

  task automatic t_cpu_priority();
    do_reset();
    write_pol(pol(0, 1, 3'd0));
    req = 3'b111; tick();
    check("R5 CPU wins burst 0", G_CPU);
    finish_access(G_CPU);
    check("R5 CPU wins again", G_CPU);
    req = G_DMA | G_OCP; finish_access(G_CPU);
    check("R8 DMA first after CPU drops", G_DMA);
    req = 3'b111; finish_access(G_DMA);
    check("R5 CPU beats OCP", G_CPU);
    req = '0; finish_access(G_CPU);
  endtask

  task automatic t_burst3();
    do_reset();
    write_pol(pol(0, 1, 3'd3));
    req = G_CPU; tick();
    check("R4 CPU granted alone", G_CPU);
    req = G_CPU | G_DMA; finish_access(G_CPU);
    check("R6 DMA after CPU", G_DMA);
    finish_access(G_DMA);
    check("R6 burst 1 of 3", G_DMA);
    finish_access(G_DMA);
    check("R6 burst 2 of 3", G_DMA);
    finish_access(G_DMA);
    check("R6 CPU after 3 accesses", G_CPU);
    req = '0; finish_access(G_CPU);
  endtask

  task automatic t_early_handover();
    do_reset();
    write_pol(pol(0, 1, 3'd5));
    req = G_CPU; tick();
    req = G_CPU | G_DMA; finish_access(G_CPU);
    check("R7 DMA granted", G_DMA);
    req = G_CPU; finish_access(G_DMA);
    check("R7 early CPU handover", G_CPU);
    req = '0; finish_access(G_CPU);
  endtask

  task automatic t_round_robin();
    do_reset();
    req = G_DMA | G_OCP; tick();
    check("R8 DMA first", G_DMA);
    finish_access(G_DMA);
    check("R8 OCP second", G_OCP);
    finish_access(G_OCP);
    check("R8 DMA third", G_DMA);
    req = '0; finish_access(G_DMA);
  endtask

  task automatic t_fixed();
    do_reset();
    write_pol(pol(1, 1, 3'd1));
    req = G_DMA | G_OCP; tick();
    check("R9 DMA first", G_DMA);
    finish_access(G_DMA);
    check("R9 DMA again", G_DMA);
    req = G_OCP; finish_access(G_DMA);
    check("R9 OCP when DMA idle", G_OCP);
    req = '0; finish_access(G_OCP);
  endtask

  task automatic t_shared(input bit use_fiq);
    do_reset();
    if (use_fiq) fiq = 1; else irq = 1;
    req = 3'b111; tick();
    check("R10 rotation CPU", G_CPU);
    finish_access(G_CPU);
    check("R10 rotation DMA", G_DMA);
    finish_access(G_DMA);
    check("R10 rotation OCP", G_OCP);
    finish_access(G_OCP);
    check("R10 rotation wraps to CPU", G_CPU);
    req = '0; finish_access(G_CPU);
    irq = 0; fiq = 0;
  endtask

  task automatic t_share_off();
    do_reset();
    write_pol(pol(0, 0, 3'd1));
    irq = 1; fiq = 1;
    req = 3'b111; tick();
    check("R11 flags ignored DMA first", G_DMA);
    finish_access(G_DMA);
    check("R11 CPU after burst", G_CPU);
    finish_access(G_CPU);
    check("R11 OCP by pair rotation", G_OCP);
    req = '0; finish_access(G_OCP);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    tick();
    t_reset_defaults();
    t_cpu_priority();
    t_burst3();
    t_early_handover();
    t_round_robin();
    t_fixed();
    t_shared(0);
    t_shared(1);
    t_share_off();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule